// File: doc/BRIEF.md
# Boot ROM Shadow Copier

This block fills a reserved window of SDRAM with the card's driver ROM image at power-up. It acts as the SPI master towards a serial flash. It sends a plain read command at flash address zero and keeps chip select low for the whole image, assembling the incoming bits into bytes. Each byte goes to the SDRAM controller as a write request with a valid/ready handshake, and the request targets a window that sits above the memory exposed as RAM disk.

While the copy runs, any host read of the slot ROM space returns 0xFF and no memory request is raised. Once the last byte has been accepted, a done flag rises and stays high. From then on, host ROM-space reads are turned into read requests into the shadow window. Host writes into ROM space never reach memory, so after boot the window looks like a parallel ROM to the host.

Top module: `boot_rom_shadow`

## Requirements
- R1: While reset is high and in the cycle after it, `spi_cs_n` is 1, `spi_sck` is 0, `wr_valid` is 0 and `copy_done` is 0.
- R2: After reset the block lowers `spi_cs_n` and shifts out 32 bits MSB first: the read opcode 0x03 followed by a 24-bit address of 0. `spi_mosi` is stable at every rising `spi_sck` edge (SPI mode 0, clock idles low).
- R3: Data bits are sampled on rising `spi_sck` edges and are assembled MSB first. The first bit after the 32 command bits is bit 7 of flash byte 0.
- R4: Byte i of the image is presented as `wr_data` with `wr_addr` = `SHADOW_BASE` + i, in ascending order, and every `wr_addr` lies inside [`SHADOW_BASE`, `SHADOW_BASE` + `ROM_BYTES`).
- R5: A request with `wr_ready` low keeps `wr_valid`, `wr_addr` and `wr_data` unchanged. While a byte waits, at most one further byte is shifted in, after which `spi_sck` stops toggling until the request is taken.
- R6: Exactly `ROM_BYTES` writes are accepted and exactly 32 + 8×`ROM_BYTES` rising `spi_sck` edges occur. `spi_cs_n` then returns to 1 and `spi_sck` stays low.
- R7: `copy_done` is 0 in the cycle where the final write is accepted, is 1 from the next cycle onward, and never falls before reset.
- R8: Before `copy_done`, a host ROM read returns `host_rdata` = 0xFF and `rom_rd_req` stays 0.
- R9: After `copy_done`, a host read with `host_iosel_n` = 0 or `host_iostrb_n` = 0 raises `rom_rd_req` at the same cycle, with `rom_rd_addr` = `SHADOW_BASE` + `host_off` and `host_rdata` = `rom_rd_data`.
- R10: A host write (`host_read` = 0) in ROM space, or a read with both selects high, raises no `rom_rd_req`, so the shadow is read-only to the host.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| spi_sck | output | 1 | SPI clock, half the block clock rate, idles low |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Command bits to flash |
| spi_miso | input | 1 | Data bits from flash |
| wr_valid | output | 1 | Shadow write request valid |
| wr_ready | input | 1 | SDRAM controller accepts the write |
| wr_addr | output | RAM_AW | Byte address of the shadow write |
| wr_data | output | 8 | Byte to write |
| copy_done | output | 1 | Shadow image complete |
| host_iosel_n | input | 1 | Slot ROM page select, active low |
| host_iostrb_n | input | 1 | Expansion ROM strobe, active low |
| host_read | input | 1 | Host cycle is a read |
| host_off | input | ROM_AW | Byte offset inside the ROM image |
| rom_rd_req | output | 1 | Read request into the shadow window |
| rom_rd_addr | output | RAM_AW | SDRAM address of that read |
| rom_rd_data | input | 8 | Data returned for the shadow read |
| host_rdata | output | 8 | Byte returned to the host |

## Verification
The checker watches several rules on every cycle. It confirms that a pending write holds its address and data until taken and that every write address stays inside the shadow window. It also checks that the done flag never falls, that no write follows it, and that chip select is high and the clock low once the copy is over. It confirms that no shadow read request appears before done and that ROM reads return 0xFF until then. Other behaviour is shown only by the bench scenarios, which use a flash model. These cover the exact command word, the MSB-first byte contents, the ascending order of the writes, the total count of clock edges, and the fact that the clock stops during a long stall. They also cover the cycle in which done rises and the address mapping of host reads through each select line.

// File: rtl/boot_shadow_pkg.sv
package boot_shadow_pkg;

    localparam logic [7:0] FLASH_READ_OP = 8'h03;
    localparam int         CMD_BYTES     = 4;

    typedef enum logic [1:0] {
        SEQ_START,
        SEQ_CMD,
        SEQ_DATA,
        SEQ_END
    } seq_state_e;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic mosi;
    } spi_pins_t;

    function automatic logic [31:0] flash_cmd(input logic [23:0] start_addr);
        return {FLASH_READ_OP, start_addr};
    endfunction

endpackage

// File: rtl/flash_stream_seq.sv
module flash_stream_seq
    import boot_shadow_pkg::*;
#(
    parameter int ROM_BYTES = 4096,
    localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      miso,
    input  logic      can_push,
    output spi_pins_t pins,
    output logic      push,
    output logic      push_last,
    output logic [7:0] push_data
);
    localparam logic [ROM_AW-1:0] LAST_IDX = ROM_AW'(ROM_BYTES - 1);
    localparam logic [1:0]        LAST_CMD = 2'(CMD_BYTES - 1);

    seq_state_e        state;
    logic              sck_q;
    logic              cs_n_q;
    logic [2:0]        bit_cnt;
    logic [1:0]        cmd_cnt;
    logic [ROM_AW-1:0] byte_idx;
    logic [31:0]       cmd_sh;
    logic [7:0]        rx_sh;
    logic              byte_end;

    assign byte_end  = (state == SEQ_DATA) && sck_q && (bit_cnt == 3'd7);
    assign push      = byte_end && can_push;
    assign push_last = (byte_idx == LAST_IDX);
    assign push_data = rx_sh;

    assign pins.sck  = sck_q;
    assign pins.cs_n = cs_n_q;
    assign pins.mosi = (state == SEQ_CMD) ? cmd_sh[31] : 1'b0;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SEQ_START;
            sck_q    <= 1'b0;
            cs_n_q   <= 1'b1;
            bit_cnt  <= '0;
            cmd_cnt  <= '0;
            byte_idx <= '0;
            cmd_sh   <= flash_cmd(24'h000000);
            rx_sh    <= '0;
        end else begin
            unique case (state)
                SEQ_START: begin
                    cs_n_q <= 1'b0;
                    state  <= SEQ_CMD;
                end
                SEQ_CMD: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                    end else begin
                        sck_q   <= 1'b0;
                        cmd_sh  <= {cmd_sh[30:0], 1'b0};
                        bit_cnt <= bit_cnt + 3'd1;
                        if (bit_cnt == 3'd7) begin
                            cmd_cnt <= cmd_cnt + 2'd1;
                            if (cmd_cnt == LAST_CMD) state <= SEQ_DATA;
                        end
                    end
                end
                SEQ_DATA: begin
                    if (!sck_q) begin
                        sck_q <= 1'b1;
                        rx_sh <= {rx_sh[6:0], miso};
                    end else if (!byte_end || can_push) begin
                        sck_q   <= 1'b0;
                        bit_cnt <= bit_cnt + 3'd1;
                        if (byte_end) begin
                            byte_idx <= byte_idx + 1'b1;
                            if (push_last) begin
                                cs_n_q <= 1'b1;
                                state  <= SEQ_END;
                            end
                        end
                    end
                end
                default: begin
                    sck_q  <= 1'b0;
                    cs_n_q <= 1'b1;
                end
            endcase
        end
    end
endmodule

// File: rtl/shadow_write_port.sv
module shadow_write_port #(
    parameter int ROM_BYTES = 4096,
    parameter int RAM_AW    = 25,
    parameter logic [RAM_AW-1:0] SHADOW_BASE = RAM_AW'(24'h100000) << 4,
    localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              push_last,
    input  logic [7:0]        push_data,
    input  logic              wr_ready,
    output logic              can_push,
    output logic              wr_valid,
    output logic [RAM_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              done
);
    logic              full;
    logic              last_q;
    logic              taken;
    logic [ROM_AW-1:0] wr_idx;
    logic [7:0]        data_q;

    assign taken    = full && wr_ready;
    assign can_push = !full || wr_ready;
    assign wr_valid = full;
    assign wr_data  = data_q;
    assign wr_addr  = SHADOW_BASE + RAM_AW'(wr_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            full   <= 1'b0;
            last_q <= 1'b0;
            wr_idx <= '0;
            data_q <= '0;
            done   <= 1'b0;
        end else begin
            if (push) begin
                full   <= 1'b1;
                data_q <= push_data;
                if (push_last) last_q <= 1'b1;
            end else if (taken) begin
                full <= 1'b0;
            end
            if (taken) wr_idx <= wr_idx + 1'b1;
            if (taken && last_q) done <= 1'b1;
        end
    end
endmodule

// File: rtl/host_rom_map.sv
module host_rom_map #(
    parameter int ROM_BYTES = 4096,
    parameter int RAM_AW    = 25,
    parameter logic [RAM_AW-1:0] SHADOW_BASE = RAM_AW'(24'h100000) << 4,
    localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
    input  logic              done,
    input  logic              iosel_n,
    input  logic              iostrb_n,
    input  logic              rd,
    input  logic [ROM_AW-1:0] off,
    input  logic [7:0]        mem_rdata,
    output logic              req,
    output logic [RAM_AW-1:0] req_addr,
    output logic [7:0]        rdata
);
    logic rom_space;

    always_comb begin
        rom_space = !iosel_n || !iostrb_n;
        req       = done && rom_space && rd;
        req_addr  = SHADOW_BASE + RAM_AW'(off);
        rdata     = done ? mem_rdata : 8'hFF;
    end
endmodule

// File: rtl/boot_rom_shadow.sv
module boot_rom_shadow
    import boot_shadow_pkg::*;
#(
    parameter int ROM_BYTES = 4096,
    parameter int RAM_AW    = 25,
    parameter logic [RAM_AW-1:0] SHADOW_BASE = RAM_AW'(24'h100000) << 4,
    localparam int ROM_AW   = $clog2(ROM_BYTES)
) (
    input  logic              clk,
    input  logic              rst,
    output logic              spi_sck,
    output logic              spi_cs_n,
    output logic              spi_mosi,
    input  logic              spi_miso,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [RAM_AW-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              copy_done,
    input  logic              host_iosel_n,
    input  logic              host_iostrb_n,
    input  logic              host_read,
    input  logic [ROM_AW-1:0] host_off,
    output logic              rom_rd_req,
    output logic [RAM_AW-1:0] rom_rd_addr,
    input  logic [7:0]        rom_rd_data,
    output logic [7:0]        host_rdata
);
    spi_pins_t  pins;
    logic       push;
    logic       push_last;
    logic [7:0] push_data;
    logic       can_push;

    assign spi_sck  = pins.sck;
    assign spi_cs_n = pins.cs_n;
    assign spi_mosi = pins.mosi;

    flash_stream_seq #(.ROM_BYTES(ROM_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .miso      (spi_miso),
        .can_push  (can_push),
        .pins      (pins),
        .push      (push),
        .push_last (push_last),
        .push_data (push_data)
    );

    shadow_write_port #(
        .ROM_BYTES   (ROM_BYTES),
        .RAM_AW      (RAM_AW),
        .SHADOW_BASE (SHADOW_BASE)
    ) u_wport (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_last (push_last),
        .push_data (push_data),
        .wr_ready  (wr_ready),
        .can_push  (can_push),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .done      (copy_done)
    );

    host_rom_map #(
        .ROM_BYTES   (ROM_BYTES),
        .RAM_AW      (RAM_AW),
        .SHADOW_BASE (SHADOW_BASE)
    ) u_map (
        .done      (copy_done),
        .iosel_n   (host_iosel_n),
        .iostrb_n  (host_iostrb_n),
        .rd        (host_read),
        .off       (host_off),
        .mem_rdata (rom_rd_data),
        .req       (rom_rd_req),
        .req_addr  (rom_rd_addr),
        .rdata     (host_rdata)
    );
endmodule

// File: rtl/boot_rom_shadow_chk.sv
module boot_rom_shadow_chk #(
    parameter int ROM_BYTES = 4096,
    parameter int RAM_AW    = 25,
    parameter logic [RAM_AW-1:0] SHADOW_BASE = RAM_AW'(24'h100000) << 4
) (
    input logic              clk,
    input logic              rst,
    input logic              spi_sck,
    input logic              spi_cs_n,
    input logic              wr_valid,
    input logic              wr_ready,
    input logic [RAM_AW-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic              copy_done,
    input logic              rom_rd_req,
    input logic [7:0]        host_rdata
);
    localparam logic [RAM_AW:0] WIN_LO = {1'b0, SHADOW_BASE};
    localparam logic [RAM_AW:0] WIN_HI = WIN_LO + (RAM_AW+1)'(ROM_BYTES);

    // R5
    hold_req_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R4
    win_addr_chk: assert property (@(posedge clk) disable iff (rst)
        wr_valid |-> ({1'b0, wr_addr} >= WIN_LO) && ({1'b0, wr_addr} < WIN_HI));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        copy_done |=> copy_done);

    // R7
    no_write_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        copy_done |-> !wr_valid);

    // R6
    bus_idle_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        copy_done |-> spi_cs_n && !spi_sck);

    // R2
    sck_low_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        spi_cs_n |-> !spi_sck);

    // R8
    no_req_early_chk: assert property (@(posedge clk) disable iff (rst)
        rom_rd_req |-> copy_done);

    // R8
    blank_early_chk: assert property (@(posedge clk) disable iff (rst)
        !copy_done |-> host_rdata == 8'hFF);
endmodule

bind boot_rom_shadow boot_rom_shadow_chk #(
    .ROM_BYTES   (ROM_BYTES),
    .RAM_AW      (RAM_AW),
    .SHADOW_BASE (SHADOW_BASE)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .spi_sck    (spi_sck),
    .spi_cs_n   (spi_cs_n),
    .wr_valid   (wr_valid),
    .wr_ready   (wr_ready),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .copy_done  (copy_done),
    .rom_rd_req (rom_rd_req),
    .host_rdata (host_rdata)
);

// File: tb/boot_rom_shadow_tb.sv
`timescale 1ns/1ps
module boot_rom_shadow_tb;
    localparam int ROM_BYTES = 64;
    localparam int RAM_AW    = 25;
    localparam int ROM_AW    = $clog2(ROM_BYTES);
    localparam logic [RAM_AW-1:0] BASE = 25'h1000000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic spi_sck, spi_cs_n, spi_mosi;
    logic spi_miso = 1'b0;
    logic wr_valid, copy_done, rom_rd_req;
    logic wr_ready = 1'b0;
    logic [RAM_AW-1:0] wr_addr, rom_rd_addr;
    logic [7:0] wr_data, host_rdata, rom_rd_data;
    logic host_iosel_n = 1'b1, host_iostrb_n = 1'b1, host_read = 1'b1;
    logic [ROM_AW-1:0] host_off = '0;

    boot_rom_shadow #(.ROM_BYTES(ROM_BYTES), .RAM_AW(RAM_AW), .SHADOW_BASE(BASE)) u_dut (
        .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso), .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
        .wr_data(wr_data), .copy_done(copy_done), .host_iosel_n(host_iosel_n),
        .host_iostrb_n(host_iostrb_n), .host_read(host_read), .host_off(host_off),
        .rom_rd_req(rom_rd_req), .rom_rd_addr(rom_rd_addr), .rom_rd_data(rom_rd_data),
        .host_rdata(host_rdata));

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    function automatic logic [7:0] img(input int i);
        return 8'((i * 37 + 5) & 8'hFF);
    endfunction
    assign rom_rd_data = rom_rd_addr[7:0] ^ 8'h5A;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash model, mode 0
    int flash_bits = 0;
    logic [31:0] flash_cmd_word = '0;
    always @(negedge spi_cs_n) begin
        flash_bits = 0;
        flash_cmd_word = '0;
    end
    always @(posedge spi_sck) if (!spi_cs_n) begin
        if (flash_bits < 32) flash_cmd_word = {flash_cmd_word[30:0], spi_mosi};
        flash_bits++;
    end
    always @(negedge spi_sck) if (!spi_cs_n && flash_bits >= 32) begin
        automatic int k = flash_bits - 32;
        automatic logic [7:0] b = img(k / 8);
        spi_miso = b[7 - (k % 8)];
    end

    // ready driver
    int ready_mode = 0;
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        #1;
        case (ready_mode)
            0: wr_ready = 1'b0;
            1: wr_ready = (cyc % 3) != 0;
            default: wr_ready = 1'b1;
        endcase
    end

    // write monitor
    int wr_count = 0;
    bit done_due = 0;
    int sck_rises = 0;
    logic sck_prev = 1'b0;
    always @(negedge clk) begin
        if (!rst && spi_sck && !sck_prev) sck_rises++;
        sck_prev = spi_sck;
        if (done_due) begin
            check(copy_done == 1'b1, "R7 done one cycle after final accept", copy_done, 1);
            done_due = 0;
        end
        if (!rst && wr_valid && wr_ready) begin
            check(wr_data == img(wr_count), "R3 byte content", wr_data, img(wr_count));
            check(wr_addr == BASE + RAM_AW'(wr_count), "R4 write address", wr_addr, BASE + RAM_AW'(wr_count));
            if (wr_count == ROM_BYTES - 1) begin
                check(copy_done == 1'b0, "R7 done low at final accept", copy_done, 0);
                done_due = 1;
            end
            wr_count++;
        end
    end

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        check(0, "watchdog", cyc, 0);
        finish_run();
    end

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(spi_cs_n && !spi_sck && !wr_valid && !copy_done, "R1 reset outputs",
              {spi_cs_n, spi_sck, wr_valid, copy_done}, 4'b1000);
        @(posedge clk); #1 rst = 1'b0;
        @(negedge clk);
        check(spi_cs_n && !spi_sck && !wr_valid && !copy_done, "R1 first cycle after reset",
              {spi_cs_n, spi_sck, wr_valid, copy_done}, 4'b1000);
    endtask

    task automatic t_stall_and_blank();
        logic [7:0] held;
        int base_rises;
        while (!wr_valid) @(negedge clk);
        check(flash_cmd_word == 32'h03000000, "R2 command word", flash_cmd_word, 32'h03000000);
        check(!spi_cs_n, "R2 chip select low during copy", spi_cs_n, 0);
        held = wr_data;
        check(held == img(0), "R3 first byte MSB first", held, img(0));
        repeat (40) @(negedge clk);
        base_rises = sck_rises;
        @(posedge clk); #1 begin host_iosel_n = 1'b0; host_read = 1'b1; host_off = 6'h11; end
        @(negedge clk);
        check(host_rdata == 8'hFF, "R8 blank read before done", host_rdata, 8'hFF);
        check(!rom_rd_req, "R8 no request before done", rom_rd_req, 0);
        @(posedge clk); #1 host_iosel_n = 1'b1;
        repeat (100) @(negedge clk);
        check(sck_rises == base_rises, "R5 clock stops while stalled", sck_rises - base_rises, 0);
        check(wr_valid && wr_data == held && wr_addr == BASE, "R5 request held", wr_data, held);
        check(flash_bits == 48, "R5 one extra byte buffered", flash_bits, 48);
        ready_mode = 1;
    endtask

    task automatic t_complete();
        while (!copy_done) @(negedge clk);
        ready_mode = 2;
        @(negedge clk);
        check(wr_count == ROM_BYTES, "R6 write count", wr_count, ROM_BYTES);
        check(flash_bits == 32 + 8 * ROM_BYTES, "R6 clock edge count", flash_bits, 32 + 8 * ROM_BYTES);
        begin
            automatic int r0 = sck_rises;
            repeat (50) @(negedge clk);
            check(spi_cs_n && sck_rises == r0, "R6 bus idle after copy", sck_rises - r0, 0);
        end
        check(copy_done, "R7 done stays high", copy_done, 1);
        check(wr_count == ROM_BYTES, "R6 no extra writes", wr_count, ROM_BYTES);
    endtask

    task automatic t_host_map();
        @(posedge clk); #1 begin host_iosel_n = 1'b0; host_iostrb_n = 1'b1; host_read = 1'b1; host_off = 6'h2A; end
        @(negedge clk);
        check(rom_rd_req && rom_rd_addr == BASE + 25'h2A, "R9 slot page read address", rom_rd_addr, BASE + 25'h2A);
        check(host_rdata == (8'h2A ^ 8'h5A), "R9 read data passthrough", host_rdata, 8'h2A ^ 8'h5A);
        @(posedge clk); #1 begin host_iosel_n = 1'b1; host_iostrb_n = 1'b0; host_off = 6'h3F; end
        @(negedge clk);
        check(rom_rd_req && rom_rd_addr == BASE + 25'h3F, "R9 strobe read address", rom_rd_addr, BASE + 25'h3F);
        @(posedge clk); #1 host_read = 1'b0;
        @(negedge clk);
        check(!rom_rd_req && !wr_valid, "R10 host write ignored", rom_rd_req, 0);
        @(posedge clk); #1 begin host_iostrb_n = 1'b1; host_read = 1'b1; end
        @(negedge clk);
        check(!rom_rd_req, "R10 no select no request", rom_rd_req, 0);
    endtask

    initial begin
        t_reset();
        t_stall_and_blank();
        t_complete();
        t_host_map();
        finish_run();
    end
endmodule